// File: doc/BRIEF.md
# EEPROM Write Guard and Program-Cycle Controller

This block sits between a two-wire serial slave engine and the storage array of a serial EEPROM. It collects the data bytes of a write command in a page buffer, watches the write-protect input over a protection window, and decides whether the collected bytes are committed to the array. The window opens on the strobe that marks the capture of bit D0 of the first data byte. It stays open until the internal programming time has elapsed. A high write-protect level seen anywhere in that window abandons the write.

When the STOP condition closes a valid write command, the block raises a busy flag. It then counts a programmable number of system-clock cycles, the programming time. After that it streams the buffered bytes into the array, one byte per cycle. The slave engine uses busy to ignore every command and withhold ACK, so the host can find out when the cycle is over by acknowledge polling. A cancelled write, or a STOP with no data byte, never raises busy. The next command is therefore acknowledged at once.

Top module: `ee_write_guard`

## Requirements
- R1: After reset, busy is low and the array write enable stays low until a write command is committed.
- R2: A command of one or more data bytes that starts with addrLoad, opens the window with d0Strb and ends with stopStrb while wpPin stays low writes exactly the received bytes into the array and touches no other address.
- R3: Byte k of a command (k counted from 0) goes to address {page, (offset + k) mod PAGE_BYTES}. Here page is the upper part of wordAddr and offset is its low log2(PAGE_BYTES) bits. A later byte that lands on an index already used replaces the earlier byte, and each address is written once.
- R4: busy rises in the cycle after the accepted stopStrb and stays high for exactly WR_CYCLES + PAGE_BYTES cycles. The array writes fall in the last PAGE_BYTES of those cycles.
- R5: wpPin high in the cycle of d0Strb, in any later cycle before STOP, or in the STOP cycle itself cancels the write: the array is unchanged and busy stays low.
- R6: wpPin high during the programming time abandons the write. busy is low from the next cycle on and the array is unchanged.
- R7: A STOP that follows no data byte starts no cycle: busy stays low and nothing is written.
- R8: While busy is high, addrLoad, d0Strb, byteStrb and stopStrb are ignored. The running cycle keeps its length, and no command given during it is ever written.
- R9: wpPin high before d0Strb, after addrLoad, has no effect on the write.
- R10: A new addrLoad before STOP discards the bytes collected so far and any pending cancellation. Only the bytes that follow it are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLoad | input | 1 | Word address of a write command has been received |
| wordAddr | input | ADDR_W | Word address that goes with addrLoad |
| d0Strb | input | 1 | Bit D0 of the first data byte was captured |
| byteStrb | input | 1 | A complete data byte is available on byteData |
| byteData | input | 8 | Received data byte |
| stopStrb | input | 1 | STOP condition detected |
| wpPin | input | 1 | Write-protect level, high blocks writing |
| busy | output | 1 | Programming cycle running; the slave ignores traffic |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |

## Verification
Two pairs of events can fall in the same cycle: the write-protect level with the STOP strobe, and the write-protect level with the D0 strobe. In the first pair the cancel decision races the start of programming. In the second it races the opening of the window. The bench raises wpPin in exactly the STOP cycle, and again in exactly the D0 cycle, and expects in both cases that busy never rises and the page stays untouched. It also raises wpPin in the second programming cycle, where it expects busy to fall after two cycles with no array write.

// File: rtl/ewg_pkg.sv
package ewg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_PROG   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;

  typedef struct packed {
    logic captureAddr;
    logic acceptByte;
    logic commitStep;
  } dpCtl_t;
endpackage

// File: rtl/ewg_dpath.sv
module ewg_dpath
  import ewg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        byteIn,
  output logic              anyDirty,
  output logic              commitLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [IDX_W-1:0]      wrPtr;
  logic [IDX_W-1:0]      cmIdx;
  logic [PAGE_BYTES-1:0] dirty;
  logic [7:0]            pageBuf [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      wrPtr    <= '0;
      cmIdx    <= '0;
    end else if (ctl.captureAddr) begin
      pageBase <= addrIn[ADDR_W-1:IDX_W];
      wrPtr    <= addrIn[IDX_W-1:0];
      cmIdx    <= '0;
    end else begin
      if (ctl.acceptByte) wrPtr <= wrPtr + 1'b1;
      if (ctl.commitStep) cmIdx <= cmIdx + 1'b1;
    end
  end

  for (genvar e = 0; e < PAGE_BYTES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirty[e] <= 1'b0;
      end else if (ctl.captureAddr) begin
        dirty[e] <= 1'b0;
      end else if (ctl.acceptByte && wrPtr == IDX_W'(e)) begin
        dirty[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (ctl.acceptByte && wrPtr == IDX_W'(e)) pageBuf[e] <= byteIn;
    end
  end

  assign anyDirty   = |dirty;
  assign commitLast = (cmIdx == IDX_W'(PAGE_BYTES - 1));
  assign memWe      = ctl.commitStep & dirty[cmIdx];
  assign memAddr    = {pageBase, cmIdx};
  assign memData    = pageBuf[cmIdx];

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureAddr |=> (dirty == '0));

  // R3
  store_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.acceptByte && !ctl.captureAddr) |=> dirty[$past(wrPtr)]);
endmodule

// File: rtl/ewg_ctrl.sv
module ewg_ctrl
  import ewg_pkg::*;
#(
  parameter int WR_CYCLES = 250000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   addrLoad,
  input  logic   d0Strb,
  input  logic   byteStrb,
  input  logic   stopStrb,
  input  logic   wpPin,
  input  logic   anyDirty,
  input  logic   commitLast,
  output dpCtl_t ctl,
  output logic   busy
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  phase_e          phase;
  logic            winOpen;
  logic            cancelQ;
  logic [CNT_W-1:0] progCnt;
  logic            listening;
  logic            wpHit;
  logic            goWrite;

  always_comb begin
    listening       = (phase == PH_IDLE) || (phase == PH_LOAD);
    ctl.captureAddr = listening && addrLoad;
    ctl.acceptByte  = (phase == PH_LOAD) && byteStrb && !addrLoad;
    ctl.commitStep  = (phase == PH_COMMIT);
    wpHit           = wpPin && (winOpen || d0Strb);
    goWrite         = anyDirty && winOpen && !cancelQ && !wpPin;
    busy            = (phase == PH_PROG) || (phase == PH_COMMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      winOpen <= 1'b0;
      cancelQ <= 1'b0;
      progCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (addrLoad) begin
            phase   <= PH_LOAD;
            winOpen <= 1'b0;
            cancelQ <= 1'b0;
          end
        end
        PH_LOAD: begin
          if (addrLoad) begin
            winOpen <= 1'b0;
            cancelQ <= 1'b0;
          end else if (stopStrb) begin
            phase   <= goWrite ? PH_PROG : PH_IDLE;
            progCnt <= '0;
            winOpen <= 1'b0;
          end else begin
            if (d0Strb) winOpen <= 1'b1;
            if (wpHit)  cancelQ <= 1'b1;
          end
        end
        PH_PROG: begin
          if (wpPin) begin
            phase <= PH_IDLE;
          end else if (progCnt == CNT_W'(WR_CYCLES - 1)) begin
            phase <= PH_COMMIT;
          end else begin
            progCnt <= progCnt + 1'b1;
          end
        end
        PH_COMMIT: begin
          if (commitLast) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStrb));

  // R4
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    progCnt < CNT_W'(WR_CYCLES));

  // R5
  cancel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOAD && stopStrb && !addrLoad && (cancelQ || wpPin)) |=> !busy);

  // R6
  wp_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PROG && wpPin) |=> !busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PROG && !wpPin) |=> busy);
endmodule

// File: rtl/ee_write_guard.sv
module ee_write_guard
  import ewg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              d0Strb,
  input  logic              byteStrb,
  input  logic [7:0]        byteData,
  input  logic              stopStrb,
  input  logic              wpPin,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  dpCtl_t ctl;
  logic   anyDirty;
  logic   commitLast;

  ewg_ctrl #(.WR_CYCLES(WR_CYCLES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .addrLoad   (addrLoad),
    .d0Strb     (d0Strb),
    .byteStrb   (byteStrb),
    .stopStrb   (stopStrb),
    .wpPin      (wpPin),
    .anyDirty   (anyDirty),
    .commitLast (commitLast),
    .ctl        (ctl),
    .busy       (busy)
  );

  ewg_dpath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .addrIn     (wordAddr),
    .byteIn     (byteData),
    .anyDirty   (anyDirty),
    .commitLast (commitLast),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData)
  );
endmodule

// File: tb/ee_write_guard_tb.sv
module ee_write_guard_tb_top;
  localparam int AW   = 8;
  localparam int PG   = 8;
  localparam int WRC  = 20;
  localparam int FULL = WRC + PG;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrLoad = 1'b0;
  logic [AW-1:0] wordAddr = '0;
  logic          d0Strb = 1'b0;
  logic          byteStrb = 1'b0;
  logic [7:0]    byteData = '0;
  logic          stopStrb = 1'b0;
  logic          wpPin = 1'b0;
  logic          busy;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;

  int compared = 0;
  int mismatched = 0;
  int wrCount = 0;
  logic [7:0] seenMem [256];
  logic [7:0] expMem  [256];

  // fields: page[15:11], offset[10:8], byte count[7:4], wp phase[3:0]
  // wp phase: 0 none, 1 before D0, 2 at D0, 3 after D0, 4 at STOP, 5 during programming
  localparam logic [15:0] VEC [NVEC] = '{
    {5'd1,  3'd0, 4'd1,  4'd0},
    {5'd2,  3'd3, 4'd4,  4'd0},
    {5'd3,  3'd5, 4'd8,  4'd0},
    {5'd4,  3'd2, 4'd10, 4'd0},
    {5'd5,  3'd0, 4'd3,  4'd1},
    {5'd6,  3'd0, 4'd3,  4'd2},
    {5'd7,  3'd1, 4'd3,  4'd3},
    {5'd8,  3'd0, 4'd2,  4'd4},
    {5'd9,  3'd0, 4'd2,  4'd5},
    {5'd10, 3'd0, 4'd0,  4'd0}
  };

  ee_write_guard #(.ADDR_W(AW), .PAGE_BYTES(PG), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .wordAddr(wordAddr),
    .d0Strb(d0Strb), .byteStrb(byteStrb), .byteData(byteData),
    .stopStrb(stopStrb), .wpPin(wpPin), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && memWe) begin
      seenMem[memAddr] = memData;
      wrCount++;
    end
  end

  function automatic logic [7:0] datOf(input int v, input int i);
    return 8'(8'h31 * (v + 1) + 8'h07 * i);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic checkPage(input string req, input int pg);
    for (int k = 0; k < PG; k++)
      check(req, int'(seenMem[pg * PG + k]), int'(expMem[pg * PG + k]));
  endtask

  task automatic sendCmd(input int pg, input int off, input int n, input int ph, input int v);
    @(negedge clk); addrLoad = 1'b1; wordAddr = AW'(pg * PG + off);
    @(negedge clk); addrLoad = 1'b0; wpPin = (ph == 1);
    @(negedge clk); wpPin = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteStrb = 1'b1; byteData = datOf(v, i); d0Strb = (i == 0);
      wpPin = (ph == 2 && i == 0);
      @(negedge clk);
      byteStrb = 1'b0; d0Strb = 1'b0; wpPin = (ph == 3 && i == 0);
    end
    @(negedge clk); stopStrb = 1'b1; wpPin = (ph == 4);
  endtask

  task automatic runTxn(input int pg, input int off, input int n, input int ph,
                        input int v, output int busyCnt);
    sendCmd(pg, off, n, ph, v);
    @(negedge clk); stopStrb = 1'b0; wpPin = 1'b0;
    busyCnt = 0;
    while (busy && busyCnt < 1000) begin
      busyCnt++;
      if (ph == 5 && busyCnt == 2) wpPin = 1'b1;
      @(negedge clk);
      wpPin = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    mismatched++;
    finishRun();
  end

  initial begin
    int bc;
    int w0;
    for (int a = 0; a < 256; a++) begin
      seenMem[a] = 8'h00;
      expMem[a]  = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy in reset", int'(busy), 0);
    check("R1 write enable in reset", int'(memWe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 no writes after reset", wrCount, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      int pg  = int'(VEC[v][15:11]);
      int off = int'(VEC[v][10:8]);
      int n   = int'(VEC[v][7:4]);
      int ph  = int'(VEC[v][3:0]);
      bit doWr = (n > 0) && (ph <= 1);
      int expBusy = doWr ? FULL : ((ph == 5 && n > 0) ? 2 : 0);
      int expWr = doWr ? ((n < PG) ? n : PG) : 0;
      if (doWr)
        for (int i = 0; i < n; i++) expMem[pg * PG + ((off + i) % PG)] = datOf(v, i);
      w0 = wrCount;
      runTxn(pg, off, n, ph, v, bc);
      check($sformatf("R4/R5/R6/R7 busy length vec%0d", v), bc, expBusy);
      check($sformatf("R2/R3 write count vec%0d", v), wrCount - w0, expWr);
      checkPage($sformatf("R2/R3/R5/R6/R9 page data vec%0d", v), pg);
      repeat (2) @(negedge clk);
    end

    // R8: a whole command during busy is ignored
    expMem[12 * PG + 0] = datOf(20, 0);
    expMem[12 * PG + 1] = datOf(20, 1);
    w0 = wrCount;
    sendCmd(12, 0, 2, 0, 20);
    @(negedge clk); stopStrb = 1'b0;
    bc = 1;
    sendCmd(13, 0, 3, 0, 21);
    bc = bc + 10;
    @(negedge clk); stopStrb = 1'b0;
    while (busy && bc < 1000) begin
      bc++;
      @(negedge clk);
    end
    check("R8 busy length unchanged", bc, FULL);
    check("R8 write count", wrCount - w0, 2);
    checkPage("R8 running page", 12);
    checkPage("R8 ignored page", 13);
    repeat (4) @(negedge clk);
    check("R8 no late cycle", int'(busy), 0);

    // R10: restart before STOP drops earlier bytes and a pending cancel
    @(negedge clk); addrLoad = 1'b1; wordAddr = AW'(14 * PG);
    @(negedge clk); addrLoad = 1'b0;
    @(negedge clk); byteStrb = 1'b1; d0Strb = 1'b1; byteData = 8'hA5; wpPin = 1'b1;
    @(negedge clk); byteStrb = 1'b0; d0Strb = 1'b0; wpPin = 1'b0;
    expMem[15 * PG + 4] = datOf(30, 0);
    w0 = wrCount;
    runTxn(15, 4, 1, 0, 30, bc);
    check("R10 busy length", bc, FULL);
    check("R10 write count", wrCount - w0, 1);
    checkPage("R10 discarded page", 14);
    checkPage("R10 new page", 15);

    // final sweep of the whole array
    for (int a = 0; a < 256; a++)
      if (seenMem[a] != expMem[a]) check("R2 array sweep", int'(seenMem[a]), int'(expMem[a]));
    check("R2 array sweep done", 1, 1);
    finishRun();
  end
endmodule